// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose I/O Port

This block is a general-purpose I/O port with one latch per bit and no direction register. A bit's direction follows from its latch value. A latch holding 0 pulls the pin hard to ground. A latch holding 1 lets go of the pin and leaves it to a weak pull-up. An outside device can then pull the line low, so the bit acts as an input. To use a bit as an input, software writes a 1 to it.

The pad is shown as three separate enables: a strong sink, a strong source and a weak pull-up. The sensed level comes back on a pin input. A parameter chooses the pull-up mode for each bit. In the boosted mode, the strong source turns on for a short time when a bit's latch goes from 0 to 1, so the rising edge is sharper. The bus side has a latch write and one registered read port. A select input on that read port picks either the latch contents or the synchronized pin level.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is 1. `drv_low` and `drv_high` are 0, `rd_data` is 0, and `pull_weak` is 1 on every bit whose mode is not "none".
- R2: When `wr_en` is sampled high at a clock edge, the latch takes `wr_data`. From that edge on, `drv_low` is the inverse of the latch, bit by bit.
- R3: Each bit's pull mode is a 2-bit field in `PULL_MODE` at bits [2i+1:2i]. 0 means no pull, 1 means weak pull, and 2 means weak pull plus a strong pulse. `pull_weak[i]` is 1 exactly when the latch bit is 1 and the mode is not 0. `drv_high[i]` stays 0 for modes 0 and 1.
- R4: In mode 2, a write that changes a latch bit from 0 to 1 sets `drv_high` for exactly two cycles, starting at that write edge.
- R5: A write that leaves a bit at 1 does not restart or extend a strong pulse that is already running.
- R6: A write of 0 ends a running strong pulse at that same edge. `drv_high` and `drv_low` are never both 1 on the same bit.
- R7: A clock edge with `rd_en`=1 and `rd_src`=0 loads the latch value held before that edge into `rd_data`.
- R8: A clock edge with `rd_en`=1 and `rd_src`=1 loads the pin level through a two-flop synchronizer. A change on `pin_in` set up before edge k appears in a pin read taken at edge k+2.
- R9: `rd_data` keeps its value at every edge where `rd_en` is 0.
- R10: On a bit whose latch is 1 and whose pin is pulled low from outside, a latch read returns 1 and a pin read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Value written to the latch |
| rd_en | input | 1 | Read strobe, loads `rd_data` |
| rd_src | input | 1 | Read source: 0 = latch, 1 = synchronized pin |
| rd_data | output | WIDTH | Registered read result |
| pin_in | input | WIDTH | Sensed pad level |
| drv_low | output | WIDTH | Strong sink enable |
| drv_high | output | WIDTH | Momentary strong source enable |
| pull_weak | output | WIDTH | Weak pull-up enable |

## Verification
The hardest cases to reach are the ones where a write lands on a bit while its strong pulse is still running. The bench rewrites a 1 one cycle after a 0-to-1 transition to check that the pulse does not restart. It also writes a 0 inside the pulse window to check that the pulse is cut short. After that, random writes, reads and pin changes are checked cycle by cycle against a behavioural model. The default mode vector mixes all three pull modes, so every variant is covered.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  localparam logic [1:0] PULL_NONE  = 2'd0;
  localparam logic [1:0] PULL_WEAK  = 2'd1;
  localparam logic [1:0] PULL_BOOST = 2'd2;

  function automatic logic mode_has_weak(input logic [1:0] m);
    return m != PULL_NONE;
  endfunction

  function automatic logic mode_has_boost(input logic [1:0] m);
    return m == PULL_BOOST;
  endfunction
endpackage

// File: rtl/qbio_bit_ctl.sv
module qbio_bit_ctl
  import qbio_pkg::*;
#(
  parameter logic [1:0] MODE      = PULL_WEAK,
  parameter int         PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic lat_q,
  output logic drv_low,
  output logic drv_high,
  output logic pull_weak
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_LEN);

  logic          lat_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // latch next state
  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d = wr_bit;
  end

  // pulse counter next state
  generate
    if (mode_has_boost(MODE)) begin : g_boost
      always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        if (wr_en) begin
          if (!wr_bit)                 cnt_d = '0;
          else if (!lat_q)             cnt_d = CNT_LOAD;
        end
      end
    end else begin : g_noboost
      always_comb cnt_d = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lat_q <= lat_d;
      cnt_q <= cnt_d;
    end
  end

  assign drv_low   = ~lat_q;
  assign drv_high  = (cnt_q != '0);
  assign pull_weak = lat_q & mode_has_weak(MODE);
endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_s
);
  logic [WIDTH-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      pin_s    <= '1;
    end else begin
      stage1_q <= pin_in;
      pin_s    <= stage1_q;
    end
  end
endmodule

// File: rtl/qbio_rd.sv
module qbio_rd #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_src,
  input  logic [WIDTH-1:0] lat,
  input  logic [WIDTH-1:0] pin_s,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] rd_d;

  always_comb begin
    rd_d = rd_data;
    if (rd_en) rd_d = rd_src ? pin_s : lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int                 WIDTH     = 8,
  parameter logic [2*WIDTH-1:0] PULL_MODE = 16'hAAA4,
  parameter int                 PULSE_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_src,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] drv_low,
  output logic [WIDTH-1:0] drv_high,
  output logic [WIDTH-1:0] pull_weak
);
  logic [WIDTH-1:0] lat;
  logic [WIDTH-1:0] pin_s;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    qbio_bit_ctl #(
      .MODE      (PULL_MODE[2*i +: 2]),
      .PULSE_LEN (PULSE_LEN)
    ) u_bit (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_bit    (wr_data[i]),
      .lat_q     (lat[i]),
      .drv_low   (drv_low[i]),
      .drv_high  (drv_high[i]),
      .pull_weak (pull_weak[i])
    );
  end

  qbio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .pin_s  (pin_s)
  );

  qbio_rd #(.WIDTH(WIDTH)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_src  (rd_src),
    .lat     (lat),
    .pin_s   (pin_s),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk
  import qbio_pkg::*;
#(
  parameter int                 WIDTH     = 8,
  parameter logic [2*WIDTH-1:0] PULL_MODE = 16'hAAA4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] drv_low,
  input logic [WIDTH-1:0] drv_high
);
  logic [WIDTH-1:0] boost_mask;
  always_comb
    for (int i = 0; i < WIDTH; i++)
      boost_mask[i] = mode_has_boost(PULL_MODE[2*i +: 2]);

  // R2
  wr_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> drv_low == ~$past(wr_data));

  // R6
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low & drv_high) == '0);

  // R3
  boost_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_high & ~boost_mask) == '0);

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_high & ~$past(drv_high) & ~$past(drv_low)) == '0);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind qbio_port qbio_port_chk #(.WIDTH(WIDTH), .PULL_MODE(PULL_MODE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .drv_low  (drv_low),
  .drv_high (drv_high)
);

// File: tb/qbio_port_tb_top.sv
module qbio_port_tb_top;
  localparam int W = 8;
  localparam logic [2*W-1:0] MODES = 16'hAAA4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rd_src = 1'b0;
  logic [W-1:0] wr_data = '0, pin_in = '1;
  logic [W-1:0] rd_data, drv_low, drv_high, pull_weak;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbio_port #(.WIDTH(W), .PULL_MODE(MODES), .PULSE_LEN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_src(rd_src), .rd_data(rd_data), .pin_in(pin_in),
    .drv_low(drv_low), .drv_high(drv_high), .pull_weak(pull_weak));

  // behavioural reference
  bit m_lat[W];
  int m_cnt[W];
  logic [W-1:0] m_s1, m_s2, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < W; i++) begin m_lat[i] = 1; m_cnt[i] = 0; end
      m_s1 = '1; m_s2 = '1; m_rd = '0;
    end else begin
      if (rd_en) begin
        if (rd_src) m_rd = m_s2;
        else for (int i = 0; i < W; i++) m_rd[i] = m_lat[i];
      end
      m_s2 = m_s1; m_s1 = pin_in;
      for (int i = 0; i < W; i++) begin
        if (m_cnt[i] > 0) m_cnt[i]--;
        if (wr_en) begin
          if (!wr_data[i]) m_cnt[i] = 0;
          else if (!m_lat[i] && MODES[2*i +: 2] == 2'd2) m_cnt[i] = 2;
          m_lat[i] = wr_data[i];
        end
      end
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    logic [W-1:0] e_lo, e_hi, e_pw;
    for (int i = 0; i < W; i++) begin
      e_lo[i] = !m_lat[i];
      e_hi[i] = m_cnt[i] > 0;
      e_pw[i] = m_lat[i] && MODES[2*i +: 2] != 2'd0;
    end
    chk("R2 drv_low", drv_low, e_lo);
    chk("R3 pull_weak", pull_weak, e_pw);
    chk("R4 drv_high", drv_high, e_hi);
    chk("R7 rd_data", rd_data, m_rd);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic wr(logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*2);
    @(negedge clk);
    // R1 reset state
    chk("R1 drv_low", drv_low, 8'h00);
    chk("R1 drv_high", drv_high, 8'h00);
    chk("R1 pull_weak", pull_weak, 8'hFE);
    chk("R1 rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    cyc(); cyc();
    rd_en = 1'b1; rd_src = 1'b0; cyc(); rd_en = 1'b0;
    chk("R1 latch read", rd_data, 8'hFF);

    // R4 pulse length
    wr(8'h00);
    chk("R2 sink all", drv_low, 8'hFF);
    wr(8'hFF);
    chk("R4 pulse c1", drv_high, 8'hFC);
    cyc();
    chk("R4 pulse c2", drv_high, 8'hFC);
    cyc();
    chk("R4 pulse end", drv_high, 8'h00);

    // R5 rewrite of 1 does not retrigger
    wr(8'h00);
    wr(8'hFF);
    wr(8'hFF);
    chk("R5 still c2", drv_high, 8'hFC);
    cyc();
    chk("R5 no extend", drv_high, 8'h00);

    // R6 write 0 cuts pulse
    wr(8'h00);
    wr(8'hFF);
    wr(8'h0F);
    chk("R6 cut high", drv_high, 8'h0C);
    chk("R6 sink", drv_low, 8'hF0);
    cyc(); cyc();
    wr(8'hFF); cyc(); cyc();

    // R8 synchronizer latency
    pin_in = 8'hFF; cyc(); cyc(); cyc();
    pin_in = 8'hA5; rd_en = 1'b1; rd_src = 1'b1;
    cyc();
    chk("R8 lat1", rd_data, 8'hFF);
    cyc();
    chk("R8 lat2", rd_data, 8'hFF);
    cyc();
    chk("R8 seen", rd_data, 8'hA5);

    // R10 input use: latch 1, pin pulled low
    rd_src = 1'b0; cyc();
    chk("R10 latch read", rd_data, 8'hFF);
    rd_src = 1'b1; cyc();
    chk("R10 pin read", rd_data, 8'hA5);

    // R9 hold when not reading
    rd_en = 1'b0; pin_in = 8'h3C; wr_en = 1'b1; wr_data = 8'h11;
    cyc(); wr_en = 1'b0; cyc(); cyc();
    chk("R9 hold", rd_data, 8'hA5);

    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      wr_en   = ($urandom % 3) == 0;
      wr_data = W'($urandom);
      rd_en   = $urandom % 2;
      rd_src  = $urandom % 2;
      if ($urandom % 4 == 0) pin_in = W'($urandom);
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule